// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block takes received Ethernet frames, presented one byte per cycle with an end-of-frame marker and a bad-CRC flag, and stores them in memory buffers. Each buffer is described by a four-word descriptor that lives in memory. The engine reads each descriptor through a word-wide memory master port with a valid/ready handshake. It packs the frame bytes little-endian into the buffer that the descriptor names. When the buffer is done, it writes a status word back and moves on to the next descriptor.

Software prepares the descriptors, sets the ownership bit in each one and loads the ring base. It then raises the start-receive control bit. The engine samples the ring base at that moment. A frame that does not fit in one buffer spills into the next owned descriptor. When the engine finds a descriptor it does not own, it discards the frame and counts a missed frame.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is held and in the cycle after it, `mem_valid` and `in_ready` are low and `missed_count` is zero.
- R2: Before `rx_start` is seen high, no byte is accepted and no memory request is made. When `rx_start` is first seen high, `ring_base` is sampled and the first descriptor is read from that address. Later changes to `ring_base` have no effect until the next start.
- R3: A descriptor is four words, read in this order: status at +0, control at +4 (buffer size in bits 10:0, chain flag in bit 24), buffer address at +8 and next-descriptor address at +12.
- R4: With the chain flag set, the next descriptor address is word +12. With the flag clear, the next descriptor is at the current address plus 16.
- R5: If the status word read at the start of a frame has bit 31 clear, the whole frame is consumed and discarded, the descriptor is not written, and `missed_count` rises by one. The counter saturates. The same descriptor is tried again for the next frame.
- R6: Frame byte k of a buffer goes to byte lane (k mod 4) of the word at buffer address + 4*(k div 4). Partial final words use `mem_wstrb`, so bytes past the end of the frame are left unchanged.
- R7: A frame longer than the buffer size continues into the following descriptors. Status bit 9 (first) is set only on the first of them and bit 8 (last) only on the final one. A frame that ends exactly at a buffer's end finishes in that descriptor.
- R8: Each written-back status word has bit 31 clear. On the last descriptor, bits 29:16 hold the total number of bytes received, CRC bytes included. On the other descriptors this field is zero.
- R9: Status bit 10 (multicast) equals bit 0 of the frame's first byte and appears on every descriptor of the frame.
- R10: On the last descriptor only: bit 1 equals the bad-CRC flag given with the final byte, bit 7 is set when the length exceeds 1518, bit 11 is set when the length is below 64, and bit 15 is the OR of these three.
- R11: If a descriptor needed to continue a frame is not owned, the rest of the frame is discarded and `missed_count` rises by one. The descriptor already filled keeps its first bit and has no last bit.
- R12: Every memory request has a word-aligned address. Address, direction, data and strobes hold steady while `mem_valid` is high and `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_start | input | 1 | Start-receive control bit |
| ring_base | input | ADDR_W | Address of the first descriptor |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final one of its frame |
| in_crc_err | input | 1 | Frame failed its CRC check; read with the final byte |
| in_ready | output | 1 | Engine takes the byte this cycle |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_wstrb | output | DATA_W/8 | Byte write enables |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| missed_count | output | MISS_W | Frames discarded for lack of an owned descriptor |

## Verification
The assertions assume that memory returns read data in the same cycle as `mem_ready`. They also assume that no buffer overlaps a descriptor, so a full-word write to the current descriptor address can only be a status write-back. The stimulus keeps to this: descriptors sit in their own region, each buffer has a 2 KiB slot of its own, and the memory model answers only through the handshake, with a repeating stall pattern. Descriptors are changed by the bench only between frames, while the engine waits for the next frame.

// File: rtl/rxd_pkg.sv
// Shared constants and types for the receive descriptor DMA engine.
// Bit positions are those that software decodes in the descriptor words.
package rxd_pkg;
    localparam int unsigned OWN_BIT    = 31;
    localparam int unsigned FIRST_BIT  = 9;
    localparam int unsigned LAST_BIT   = 8;
    localparam int unsigned MCAST_BIT  = 10;
    localparam int unsigned ERRSUM_BIT = 15;
    localparam int unsigned CRCERR_BIT = 1;
    localparam int unsigned LONG_BIT   = 7;
    localparam int unsigned RUNT_BIT   = 11;
    localparam int unsigned CHAIN_BIT  = 24;
    localparam int unsigned LEN_LSB    = 16;
    localparam int unsigned LEN_W      = 14;
    localparam int unsigned SIZE_W     = 11;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_WAIT,
        ST_RD_STAT,
        ST_RD_CTRL,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_DATA,
        ST_WR_DATA,
        ST_WR_STAT,
        ST_DRAIN
    } eng_state_t;
endpackage

// File: rtl/rxd_byte_packer.sv
// Collects bytes into one little-endian word with per-lane strobes.
// Assumes push and clear never arrive together and that at most
// LANES pushes occur between clears.
module rxd_byte_packer #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  push,
    input  logic [7:0]            byte_in,
    output logic [DATA_W-1:0]     word,
    output logic [DATA_W/8-1:0]   strb,
    output logic                  lane_last
);
    localparam int LANES = DATA_W / 8;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LW-1:0] lane_q;

    // Next free lane; returns to zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) lane_q <= '0;
        else if (push)       lane_q <= lane_q + 1'b1;
    end

    assign lane_last = (lane_q == LW'(LANES - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] b_q;
        logic       v_q;

        // Capture the byte for this lane and mark it present
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                b_q <= '0;
                v_q <= 1'b0;
            end else if (push && lane_q == LW'(g)) begin
                b_q <= byte_in;
                v_q <= 1'b1;
            end
        end

        assign word[g*8 +: 8] = b_q;
        assign strb[g]        = v_q;
    end
endmodule

// File: rtl/rxd_status_gen.sv
// Builds the status word written back to a descriptor.
// Length and error fields are filled only for the final descriptor of a frame.
module rxd_status_gen
    import rxd_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518
) (
    input  logic             first,
    input  logic             last,
    input  logic             mcast,
    input  logic             crc_err,
    input  logic [LEN_W-1:0] flen,
    output logic [31:0]      word
);
    logic runt, too_long, bad_crc;

    // Compose the status word; ownership bit stays clear
    always_comb begin
        runt     = last && (32'(flen) < MIN_FRAME);
        too_long = last && (32'(flen) > MAX_FRAME);
        bad_crc  = last && crc_err;
        word     = '0;
        word[LEN_LSB +: LEN_W] = last ? flen : '0;
        word[FIRST_BIT]  = first;
        word[LAST_BIT]   = last;
        word[MCAST_BIT]  = mcast;
        word[CRCERR_BIT] = bad_crc;
        word[LONG_BIT]   = too_long;
        word[RUNT_BIT]   = runt;
        word[ERRSUM_BIT] = runt | too_long | bad_crc;
    end
endmodule

// File: rtl/rxd_miss_counter.sv
// Saturating counter of frames discarded for lack of an owned descriptor.
module rxd_miss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up by one per pulse, hold at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (inc && count != '1)  count <= count + 1'b1;
    end
endmodule

// File: rtl/rx_desc_dma.sv
// Receive descriptor DMA engine.
// Walks a list of four-word descriptors in memory and fills each owned
// buffer with frame bytes, then writes a status word back to it.
// Assumes word-aligned descriptor and buffer addresses, buffer sizes of at
// least one byte (size zero closes the descriptor empty), and memory that
// returns read data in the cycle it raises mem_ready.
module rx_desc_dma
    import rxd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MISS_W    = 16,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_start,
    input  logic [ADDR_W-1:0]    ring_base,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    input  logic                 in_crc_err,
    output logic                 in_ready,
    output logic                 mem_valid,
    output logic                 mem_write,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [DATA_W/8-1:0]  mem_wstrb,
    input  logic                 mem_ready,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [MISS_W-1:0]    missed_count
);
    localparam int STRB_W = DATA_W / 8;
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_NEXT = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] DESC_SZ  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] WORD_SZ  = ADDR_W'(STRB_W);

    eng_state_t          state;
    logic [ADDR_W-1:0]   desc_q, next_q, buf_q;
    logic [SIZE_W-1:0]   size_q, bcnt_q;
    logic                chain_q;
    logic [LEN_W-1:0]    flen_q;
    logic                first_q, mcast_q, crcerr_q, eof_q;

    logic                mem_done, accept, pk_push, pk_clear, pk_lane_last;
    logic                miss_inc, buf_full_next;
    logic [DATA_W-1:0]   pk_word;
    logic [STRB_W-1:0]   pk_strb;
    logic [31:0]         stat_word;

    assign mem_done      = mem_valid && mem_ready;
    assign in_ready      = ((state == ST_DATA) && (bcnt_q != size_q)) || (state == ST_DRAIN);
    assign accept        = in_valid && in_ready;
    assign pk_push       = accept && (state == ST_DATA);
    assign pk_clear      = (state == ST_WR_DATA) && mem_done;
    assign buf_full_next = (bcnt_q + 1'b1) == size_q;
    assign miss_inc      = (state == ST_RD_STAT) && mem_done && !mem_rdata[OWN_BIT];

    rxd_byte_packer #(.DATA_W(DATA_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pk_clear),
        .push      (pk_push),
        .byte_in   (in_data),
        .word      (pk_word),
        .strb      (pk_strb),
        .lane_last (pk_lane_last)
    );

    rxd_status_gen #(.MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)) u_stat (
        .first   (first_q),
        .last    (eof_q),
        .mcast   (mcast_q),
        .crc_err (crcerr_q),
        .flen    (flen_q),
        .word    (stat_word)
    );

    rxd_miss_counter #(.W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_inc),
        .count (missed_count)
    );

    // Drive the memory request from the current state
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        mem_wstrb = '0;
        unique case (state)
            ST_RD_STAT: mem_valid = 1'b1;
            ST_RD_CTRL: begin mem_valid = 1'b1; mem_addr = desc_q + OFS_CTRL; end
            ST_RD_BUF:  begin mem_valid = 1'b1; mem_addr = desc_q + OFS_BUF;  end
            ST_RD_NEXT: begin mem_valid = 1'b1; mem_addr = desc_q + OFS_NEXT; end
            ST_WR_DATA: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = buf_q;
                mem_wdata = pk_word;
                mem_wstrb = pk_strb;
            end
            ST_WR_STAT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = DATA_W'(stat_word);
                mem_wstrb = '1;
            end
            default: ;
        endcase
    end

    // Sequence descriptor fetch, data fill, write-back and discard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            desc_q   <= '0;
            next_q   <= '0;
            buf_q    <= '0;
            size_q   <= '0;
            bcnt_q   <= '0;
            chain_q  <= 1'b0;
            flen_q   <= '0;
            first_q  <= 1'b1;
            mcast_q  <= 1'b0;
            crcerr_q <= 1'b0;
            eof_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: if (rx_start) begin
                    desc_q <= ring_base;
                    state  <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!rx_start)     state <= ST_OFF;
                    else if (in_valid) state <= ST_RD_STAT;
                end
                ST_RD_STAT: if (mem_done) begin
                    state <= mem_rdata[OWN_BIT] ? ST_RD_CTRL : ST_DRAIN;
                end
                ST_RD_CTRL: if (mem_done) begin
                    size_q  <= mem_rdata[SIZE_W-1:0];
                    chain_q <= mem_rdata[CHAIN_BIT];
                    state   <= ST_RD_BUF;
                end
                ST_RD_BUF: if (mem_done) begin
                    buf_q  <= mem_rdata[ADDR_W-1:0];
                    bcnt_q <= '0;
                    state  <= ST_RD_NEXT;
                end
                ST_RD_NEXT: if (mem_done) begin
                    next_q <= chain_q ? mem_rdata[ADDR_W-1:0] : desc_q + DESC_SZ;
                    state  <= ST_DATA;
                end
                ST_DATA: begin
                    if (bcnt_q == size_q) begin
                        state <= ST_WR_STAT;
                    end else if (accept) begin
                        bcnt_q <= bcnt_q + 1'b1;
                        if (flen_q != '1) flen_q <= flen_q + 1'b1;
                        if (flen_q == '0) mcast_q <= in_data[0];
                        if (in_last) begin
                            eof_q    <= 1'b1;
                            crcerr_q <= in_crc_err;
                        end
                        if (in_last || pk_lane_last || buf_full_next) state <= ST_WR_DATA;
                    end
                end
                ST_WR_DATA: if (mem_done) begin
                    buf_q <= buf_q + WORD_SZ;
                    if (eof_q || bcnt_q == size_q) state <= ST_WR_STAT;
                    else                           state <= ST_DATA;
                end
                ST_WR_STAT: if (mem_done) begin
                    desc_q <= next_q;
                    if (eof_q) begin
                        first_q  <= 1'b1;
                        flen_q   <= '0;
                        mcast_q  <= 1'b0;
                        crcerr_q <= 1'b0;
                        eof_q    <= 1'b0;
                        state    <= ST_WAIT;
                    end else begin
                        first_q <= 1'b0;
                        state   <= ST_RD_STAT;
                    end
                end
                ST_DRAIN: if (accept && in_last) begin
                    first_q  <= 1'b1;
                    flen_q   <= '0;
                    mcast_q  <= 1'b0;
                    crcerr_q <= 1'b0;
                    eof_q    <= 1'b0;
                    state    <= ST_WAIT;
                end
                default: state <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/rx_desc_dma_checker.sv
// Protocol and ordering properties of the receive descriptor DMA engine.
// Assumes buffers never overlap descriptors, so a full-word write to the
// current descriptor address is a status write-back.
module rx_desc_dma_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int MISS_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_start,
    input logic                 in_ready,
    input logic                 mem_valid,
    input logic                 mem_write,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [DATA_W-1:0]    mem_wdata,
    input logic [DATA_W/8-1:0]  mem_wstrb,
    input logic                 mem_ready,
    input logic [MISS_W-1:0]    missed_count,
    input logic [ADDR_W-1:0]    desc_addr
);
    logic seen_start;

    // Remember whether start has been observed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_start <= 1'b0;
        else        seen_start <= seen_start | rx_start;
    end

    assert_quiet_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> (!in_ready && !mem_valid));

    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                       && $stable(mem_wdata) && $stable(mem_wstrb)));

    assert_word_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    assert_miss_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((missed_count == $past(missed_count)) ||
                  (missed_count == $past(missed_count) + 1'b1)));

    assert_owner_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_addr == desc_addr && mem_wstrb == '1) |-> !mem_wdata[31]);

    assert_no_byte_during_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_valid);
endmodule

bind rx_desc_dma rx_desc_dma_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .MISS_W(MISS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_start     (rx_start),
    .in_ready     (in_ready),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wstrb    (mem_wstrb),
    .mem_ready    (mem_ready),
    .missed_count (missed_count),
    .desc_addr    (desc_q)
);

// File: tb/rx_desc_dma_test.sv
`timescale 1ns/1ps
module rx_desc_dma_test;
    logic        clk = 1'b0;
    logic        rst_n, rx_start, in_valid, in_last, in_crc_err, in_ready;
    logic [31:0] ring_base;
    logic [7:0]  in_data;
    logic        mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_wstrb;
    logic [15:0] missed_count;

    logic [31:0] mem [0:4095];
    logic        hw_we;
    logic [31:0] hw_addr, hw_data;
    int          errors = 0, checks = 0, misalign = 0, cyc = 0;
    int          exp_idx;
    bit          done = 0;

    always #4 clk = ~clk;

    rx_desc_dma uut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err),
        .in_ready(in_ready), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .missed_count(missed_count)
    );

    // Memory model: combinational read, strobed write, host port for setup
    assign mem_rdata = mem[mem_addr[13:2]];
    always @(posedge clk) begin
        if (hw_we) mem[hw_addr[13:2]] <= hw_data;
        else if (mem_valid && mem_ready && mem_write)
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) mem[mem_addr[13:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    // Stall pattern on the memory port, and alignment monitor
    initial mem_ready = 1'b0;
    always @(negedge clk) begin
        cyc++;
        mem_ready = (cyc % 3) != 0;
        if (mem_valid && mem_addr[1:0] != 2'b00) misalign++;
    end

    // {len, first byte, crc flag, buffer size, descriptors used}
    localparam logic [63:0] VEC [0:6] = '{
        {16'd64,   8'h10, 8'd0, 16'd128,  16'd1},
        {16'd100,  8'h01, 8'd0, 16'd64,   16'd2},
        {16'd40,   8'h22, 8'd0, 16'd64,   16'd1},
        {16'd80,   8'h33, 8'd1, 16'd2047, 16'd1},
        {16'd1530, 8'h45, 8'd0, 16'd2047, 16'd1},
        {16'd200,  8'h02, 8'd0, 16'd64,   16'd4},
        {16'd128,  8'h00, 8'd0, 16'd64,   16'd2}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input bit f, input bit l, input bit m, input bit c, input int len);
        logic [31:0] w = '0;
        w[9] = f; w[8] = l; w[10] = m;
        if (l) begin
            w[29:16] = len[13:0];
            w[1]  = c;
            w[7]  = len > 1518;
            w[11] = len < 64;
            w[15] = c || len > 1518 || len < 64;
        end
        return w;
    endfunction

    function automatic logic [7:0] rdbyte(input int a);
        return mem[a >> 2][(a % 4) * 8 +: 8];
    endfunction

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk); hw_we = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk); hw_we = 1'b0;
    endtask

    task automatic set_desc(input int a, input logic [31:0] st, input int size, input bit chain,
                            input int bufa, input int nxt);
        host_wr(a, st);
        host_wr(a + 4, (32'(chain) << 24) | 32'(size));
        host_wr(a + 8, bufa);
        host_wr(a + 12, nxt);
    endtask

    task automatic init_ring(input int bsz);
        for (int i = 0; i < 4; i++)
            set_desc(i * 16, 32'h8000_0000, bsz, 1'b1, 32'h1000 + i * 32'h800, ((i + 1) % 4) * 16);
    endtask

    task automatic send_frame(input int len, input logic [7:0] fb, input bit crc);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb + 8'(j); in_last = (j == len - 1);
            in_crc_err = crc && (j == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
    endtask

    task automatic run_vector(input logic [63:0] v);
        int len, bsz, nd, bad, sa, di;
        logic [7:0] fb;
        bit crc;
        len = v[63:48]; fb = v[47:40]; crc = v[32]; bsz = v[31:16]; nd = v[15:0];
        init_ring(bsz);
        sa = 32'h1000 + ((exp_idx + (len - 1) / bsz) % 4) * 32'h800 + ((len - 1) % bsz) + 1;
        if ((len % bsz) % 4 != 0) host_wr(sa & ~3, 32'hA5A5_A5A5);
        send_frame(len, fb, crc);
        repeat (40) @(negedge clk);
        for (int k = 0; k < nd; k++) begin
            di = (exp_idx + k) % 4;
            check(mem[di * 4] == exp_status(k == 0, k == nd - 1, fb[0], crc, len),
                  "R3 R7 R8 R9 R10 status word", mem[di * 4],
                  exp_status(k == 0, k == nd - 1, fb[0], crc, len));
        end
        bad = 0;
        for (int j = 0; j < len; j++) begin
            di = (exp_idx + j / bsz) % 4;
            if (rdbyte(32'h1000 + di * 32'h800 + j % bsz) != fb + 8'(j)) bad++;
        end
        check(bad == 0, "R6 R4 buffer bytes", bad, 0);
        if ((len % bsz) % 4 != 0)
            check(rdbyte(sa) == 8'hA5, "R6 byte past frame kept", rdbyte(sa), 8'hA5);
        exp_idx = (exp_idx + nd) % 4;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit busy;
        rst_n = 1'b0; rx_start = 1'b0; ring_base = '0; in_valid = 1'b0; in_data = '0;
        in_last = 1'b0; in_crc_err = 1'b0; hw_we = 1'b0; hw_addr = '0; hw_data = '0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!mem_valid && !in_ready, "R1 idle in reset", {mem_valid, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_valid && !in_ready && missed_count == 0, "R1 idle after reset",
              {mem_valid, in_ready, missed_count}, 0);

        // R2: nothing happens before start
        init_ring(64);
        @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
        busy = 0;
        repeat (20) begin @(negedge clk); if (in_ready || mem_valid) busy = 1; end
        check(!busy, "R2 quiet before start", busy, 0);
        in_valid = 1'b0;
        ring_base = 32'h0; rx_start = 1'b1;
        exp_idx = 0;

        for (int v = 0; v < 7; v++) run_vector(VEC[v]);
        check(missed_count == 0, "R5 no false miss", missed_count, 0);

        // R5: unowned descriptor at frame start
        host_wr(exp_idx * 16, 32'h0000_1234);
        send_frame(64, 8'h10, 1'b0);
        repeat (40) @(negedge clk);
        check(missed_count == 1, "R5 miss counted", missed_count, 1);
        check(mem[exp_idx * 4] == 32'h1234, "R5 descriptor untouched", mem[exp_idx * 4], 32'h1234);
        host_wr(exp_idx * 16, 32'h8000_0000);
        send_frame(64, 8'h20, 1'b0);
        repeat (40) @(negedge clk);
        check(mem[exp_idx * 4] == exp_status(1, 1, 0, 0, 64), "R5 same descriptor retried",
              mem[exp_idx * 4], exp_status(1, 1, 0, 0, 64));
        check(rdbyte(32'h1000 + exp_idx * 32'h800) == 8'h20, "R5 retried data",
              rdbyte(32'h1000 + exp_idx * 32'h800), 8'h20);
        exp_idx = (exp_idx + 1) % 4;

        // R11: continuation descriptor not owned
        init_ring(64);
        host_wr(((exp_idx + 1) % 4) * 16, 32'h0000_5678);
        send_frame(100, 8'h03, 1'b0);
        repeat (40) @(negedge clk);
        check(mem[exp_idx * 4] == exp_status(1, 0, 1, 0, 100), "R11 first kept, no last",
              mem[exp_idx * 4], exp_status(1, 0, 1, 0, 100));
        check(missed_count == 2, "R11 miss counted", missed_count, 2);
        check(mem[((exp_idx + 1) % 4) * 4] == 32'h5678, "R11 unowned untouched",
              mem[((exp_idx + 1) % 4) * 4], 32'h5678);

        // R2 and R4: new base sampled at start, unchained step of 16
        rst_n = 1'b0; rx_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(missed_count == 0, "R1 counter cleared", missed_count, 0);
        host_wr(32'h0, 32'h8000_0000);
        set_desc(32'h40, 32'h8000_0000, 16, 1'b0, 32'h3000, 32'h0);
        set_desc(32'h50, 32'h8000_0000, 64, 1'b1, 32'h3800, 32'h40);
        ring_base = 32'h40; rx_start = 1'b1;
        repeat (3) @(negedge clk);
        ring_base = 32'h0;
        send_frame(40, 8'h08, 1'b0);
        repeat (40) @(negedge clk);
        check(mem[32'h40 >> 2] == exp_status(1, 0, 0, 0, 40), "R2 base used",
              mem[32'h40 >> 2], exp_status(1, 0, 0, 0, 40));
        check(mem[32'h50 >> 2] == exp_status(0, 1, 0, 0, 40), "R4 unchained next",
              mem[32'h50 >> 2], exp_status(0, 1, 0, 0, 40));
        check(mem[0] == 32'h8000_0000, "R4 word three ignored", mem[0], 32'h8000_0000);
        check(rdbyte(32'h3000) == 8'h08 && rdbyte(32'h3800) == 8'h18, "R6 R4 split bytes",
              {rdbyte(32'h3000), rdbyte(32'h3800)}, 16'h0818);
        check(misalign == 0, "R12 aligned requests", misalign, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule